// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Atomic Set/Clear

This block gives a processor control over a bank of general-purpose lines through a small register bus. The bus has an address, a write strobe with write data, and a read strobe. Read data arrives one cycle after the read strobe. The number of lines equals the register width, which is 8, 16, 32 or 64 bits.

Each line has an output latch and an output-enable bit, and the pad level of each line is sampled back in. Software can load the whole latch in one write. It can also change only chosen lines through a set word and a clear word, so no read-modify-write is needed. A direction word decides which lines are driven. Its polarity is fixed at build time: either a 1 means "drive" or a 1 means "listen". The direction word can also be left out, and then every line is always driven. Pad inputs pass through a two-stage synchronizer before software can read them.

For big-endian hosts there are two build options. One reverses the bit order, so that line n sits at register bit width-1-n. The other swaps the byte order of every register word.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: After reset, pad_out is all zeros and pad_oe is all zeros, so every line is an input. The direction word reads back 0 in drive-high polarity and all ones in listen-high polarity.
- R2: A write to the data word (address 0) loads the output latch with all lines at once. pad_out shows the new value after that clock edge.
- R3: A write to the set word (address 1) forces to 1 every latch line whose mapped write bit is 1. Lines whose bit is 0 keep their value.
- R4: A write to the clear word (address 2) forces to 0 every latch line whose mapped write bit is 1. Lines whose bit is 0 keep their value.
- R5: A write to the direction word (address 3) loads the direction bits. With DIR_IN_HIGH=0, a 1 sets pad_oe for that line. With DIR_IN_HIGH=1, a 1 clears pad_oe for that line.
- R6: With BIT_REV=1, line n corresponds to register bit REG_W-1-n in every register. With BIT_REV=0, line n corresponds to bit n.
- R7: With BYTE_REV=1, byte k of a register word corresponds to byte (REG_W/8-1-k) of the logical value, on both reads and writes. Building with BYTE_REV=1 and REG_W=64, or with any width other than 8, 16, 32 or 64, stops elaboration.
- R8: bus_rdata is registered. After an edge with bus_rd high, it carries the addressed word. After an edge with bus_rd low, it is zero. A data-word read returns the pad levels. A pad level that is stable before edge k is returned by a read sampled at edge k+2 or later.
- R9: With SET_READBACK=1, a read of the set word returns the output latch. With SET_READBACK=0, it returns zero.
- R10: With HAS_DIR=0, pad_oe is all ones at all times, including reset. Address 3 is then unmapped.
- R11: A write to address 2 or to any address of 4 and above leaves the latch and the direction bits unchanged, except for the clear action that R4 describes. Reads of the clear word and of addresses 4 and above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | REG_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | REG_W | Registered read data |
| pad_out | output | REG_W | Output latch, one bit per line |
| pad_oe | output | REG_W | Output enable, one bit per line |
| pad_in | input | REG_W | Pad levels, asynchronous |

## Verification
A latch bit set wrongly by a set or clear write shows on pad_out at the very next edge. A lost hold shows on a line the mask never touched. Both are visible on the cycle of the fault. A wrong direction bit or polarity shows on pad_oe one edge after the direction write. A synchronizer that is too short or too long shifts the first data read that returns a new pad level by one edge. A mapping error in the bit or byte order turns a single active line into the wrong bit position of bus_rdata, and also places a written mask on the wrong pad_out line.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2,
    SEL_DIR  = 2'd3
  } reg_sel_e;

  localparam int NUM_WORDS = 4;

  function automatic bit width_ok(int w);
    return (w == 8) || (w == 16) || (w == 32) || (w == 64);
  endfunction

endpackage

// File: rtl/gpio_bus_map.sv
// Permutes between a bus word and line order. Byte swap and bit reversal
// commute and each is its own inverse, so one instance serves either way.
module gpio_bus_map #(
  parameter int REG_W    = 32,
  parameter bit BIT_REV  = 1'b0,
  parameter bit BYTE_REV = 1'b0
) (
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] dout
);
  localparam int NBYTES = REG_W / 8;

  logic [REG_W-1:0] swapped;

  if (BYTE_REV) begin : g_byte_swap
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign swapped[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
    end
  end else begin : g_byte_keep
    assign swapped = din;
  end

  if (BIT_REV) begin : g_bit_rev
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
      assign dout[i] = swapped[REG_W-1-i];
    end
  end else begin : g_bit_keep
    assign dout = swapped;
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int REG_W  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] async_in,
  output logic [REG_W-1:0] sync_out
);
  logic [REG_W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
  parameter int REG_W       = 32,
  parameter bit DIR_IN_HIGH = 1'b0,
  parameter bit HAS_DIR     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dat,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_dir,
  input  logic [REG_W-1:0] lines,
  output logic [REG_W-1:0] latch,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] oe
);
  localparam logic [REG_W-1:0] DIR_RESET = DIR_IN_HIGH ? '1 : '0;

  function automatic logic [REG_W-1:0] next_latch(
    logic [REG_W-1:0] cur, logic [REG_W-1:0] m, logic ld, logic st, logic cl);
    if (ld)      return m;
    else if (st) return cur | m;
    else if (cl) return cur & ~m;
    else         return cur;
  endfunction

  logic latch_touch;
  assign latch_touch = wr_dat | wr_set | wr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch <= '0;
    else if (latch_touch) latch <= next_latch(latch, lines, wr_dat, wr_set, wr_clr);
  end

  // R2: a full write makes the latch equal the mapped word
  p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> latch == $past(lines));

  // R3: set raises the masked lines and leaves the others alone
  p_set_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((latch & $past(lines)) == $past(lines)) &&
               ((latch & ~$past(lines)) == ($past(latch) & ~$past(lines))));

  // R4: clear lowers the masked lines and leaves the others alone
  p_clr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((latch & $past(lines)) == '0) &&
               ((latch & ~$past(lines)) == ($past(latch) & ~$past(lines))));

  // R11: without a latch write the latch holds
  p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_touch |=> $stable(latch));

  if (HAS_DIR) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= DIR_RESET;
      else if (wr_dir) dir_q <= lines;
    end

    if (DIR_IN_HIGH) begin : g_in_high
      assign oe = ~dir_q;
    end else begin : g_out_high
      assign oe = dir_q;
    end

    // R5: direction bits change only on a direction write
    p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(dir_q));

    // R5: a direction write lands in the next cycle
    p_dir_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> dir_q == $past(lines));
  end else begin : g_no_dir
    assign dir_q = '0;
    assign oe    = '1;
  end

endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl #(
  parameter int REG_W        = 32,
  parameter int ADDR_W       = 4,
  parameter bit BIT_REV      = 1'b0,
  parameter bit BYTE_REV     = 1'b0,
  parameter bit DIR_IN_HIGH  = 1'b0,
  parameter bit HAS_DIR      = 1'b1,
  parameter bit SET_READBACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  pad_out,
  output logic [REG_W-1:0]  pad_oe,
  input  logic [REG_W-1:0]  pad_in
);
  import gpio_ctrl_pkg::*;

  if (!width_ok(REG_W)) begin : g_bad_width
    $error("mmio_gpio_ctrl: REG_W must be 8, 16, 32 or 64");
  end
  if (BYTE_REV && REG_W == 64) begin : g_bad_swap
    $error("mmio_gpio_ctrl: byte reversal is not available at 64 bits");
  end
  if (ADDR_W < 2) begin : g_bad_addr
    $error("mmio_gpio_ctrl: ADDR_W must be at least 2");
  end

  // decode
  reg_sel_e sel;
  logic     addr_hit;
  assign sel      = reg_sel_e'(bus_addr[1:0]);
  assign addr_hit = ((bus_addr >> 2) == '0);

  logic wr_dat, wr_set, wr_clr, wr_dir;
  assign wr_dat = bus_wr && addr_hit && (sel == SEL_DATA);
  assign wr_set = bus_wr && addr_hit && (sel == SEL_SET);
  assign wr_clr = bus_wr && addr_hit && (sel == SEL_CLR);
  assign wr_dir = bus_wr && addr_hit && (sel == SEL_DIR) && HAS_DIR;

  // R11: at most one register is written per cycle
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dat, wr_set, wr_clr, wr_dir}));

  logic [REG_W-1:0] wr_lines;
  gpio_bus_map #(.REG_W(REG_W), .BIT_REV(BIT_REV), .BYTE_REV(BYTE_REV)) u_wmap (
    .din (bus_wdata),
    .dout(wr_lines)
  );

  logic [REG_W-1:0] latch, dir_q;
  gpio_out_regs #(.REG_W(REG_W), .DIR_IN_HIGH(DIR_IN_HIGH), .HAS_DIR(HAS_DIR)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_dat(wr_dat),
    .wr_set(wr_set),
    .wr_clr(wr_clr),
    .wr_dir(wr_dir),
    .lines (wr_lines),
    .latch (latch),
    .dir_q (dir_q),
    .oe    (pad_oe)
  );
  assign pad_out = latch;

  logic [REG_W-1:0] pin_sync;
  gpio_sync #(.REG_W(REG_W), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_in),
    .sync_out(pin_sync)
  );

  // readback in line order
  logic [REG_W-1:0] rd_lines;
  always_comb begin
    rd_lines = '0;
    if (addr_hit) begin
      case (sel)
        SEL_DATA: rd_lines = pin_sync;
        SEL_SET:  rd_lines = SET_READBACK ? latch : '0;
        SEL_DIR:  rd_lines = dir_q;
        default:  rd_lines = '0;
      endcase
    end
  end

  logic [REG_W-1:0] rd_bus;
  gpio_bus_map #(.REG_W(REG_W), .BIT_REV(BIT_REV), .BYTE_REV(BYTE_REV)) u_rmap (
    .din (rd_lines),
    .dout(rd_bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_bus;
    else             bus_rdata <= '0;
  end

  // R8: idle read data is zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);

  // R11: unmapped and clear-word reads give zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (!addr_hit || sel == SEL_CLR)) |=> bus_rdata == '0);

endmodule

// File: tb/mmio_gpio_ctrl_test.sv
`timescale 1ns/1ps
module mmio_gpio_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pin_a = '0;
  logic [15:0] pin_b = '0;
  logic [7:0]  pin_c = '0;

  logic [31:0] rdata_a, out_a, oe_a;
  logic [15:0] rdata_b, out_b, oe_b;
  logic [7:0]  rdata_c, out_c, oe_c;

  int n_chk = 0;
  int n_err = 0;
  bit run_cmp = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // A: 32 bit, plain order, drive-high direction, set readable
  mmio_gpio_ctrl #(.REG_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_en), .bus_wdata(wdata),
    .bus_rd(rd_en), .bus_rdata(rdata_a), .pad_out(out_a), .pad_oe(oe_a), .pad_in(pin_a));

  // B: 16 bit, both reversals, listen-high direction, set not readable
  mmio_gpio_ctrl #(.REG_W(16), .BIT_REV(1'b1), .BYTE_REV(1'b1), .DIR_IN_HIGH(1'b1),
                   .SET_READBACK(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_en), .bus_wdata(wdata[15:0]),
    .bus_rd(rd_en), .bus_rdata(rdata_b), .pad_out(out_b), .pad_oe(oe_b), .pad_in(pin_b));

  // C: 8 bit, no direction word
  mmio_gpio_ctrl #(.REG_W(8), .HAS_DIR(1'b0)) uut_c (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_en), .bus_wdata(wdata[7:0]),
    .bus_rd(rd_en), .bus_rdata(rdata_c), .pad_out(out_c), .pad_oe(oe_c), .pad_in(pin_c));

  // ---------------- reference model ----------------
  // register bit that carries line n
  function automatic int bitpos(int n, int w, bit br, bit by);
    int p;
    p = br ? (w - 1 - n) : n;
    if (by) p = 8 * ((w / 8) - 1 - (p / 8)) + (p % 8);
    return p;
  endfunction

  function automatic logic [63:0] to_lines(logic [63:0] bus, int w, bit br, bit by);
    logic [63:0] r = '0;
    for (int n = 0; n < w; n++) r[n] = bus[bitpos(n, w, br, by)];
    return r;
  endfunction

  function automatic logic [63:0] to_bus(logic [63:0] ln, int w, bit br, bit by);
    logic [63:0] r = '0;
    for (int n = 0; n < w; n++) r[bitpos(n, w, br, by)] = ln[n];
    return r;
  endfunction

  function automatic logic [63:0] nlat(logic [63:0] cur, logic [63:0] l, int a, logic we);
    if (!we) return cur;
    case (a)
      0: return l;
      1: return cur | l;
      2: return cur & ~l;
      default: return cur;
    endcase
  endfunction

  function automatic logic [63:0] rdval(logic re, int a, logic [63:0] pins, logic [63:0] lat,
      logic [63:0] dir, bit setrd, bit hasdir, int w, bit br, bit by);
    logic [63:0] ln = '0;
    if (!re) return '0;
    case (a)
      0: ln = pins;
      1: ln = setrd ? lat : '0;
      3: ln = hasdir ? dir : '0;
      default: ln = '0;
    endcase
    return to_bus(ln, w, br, by);
  endfunction

  logic [63:0] lat_a, dir_a, h1_a, h2_a, rd_a;
  logic [63:0] lat_b, dir_b, h1_b, h2_b, rd_b;
  logic [63:0] lat_c, h1_c, h2_c, rd_c;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_a <= 0; dir_a <= 0; h1_a <= 0; h2_a <= 0; rd_a <= 0;
      lat_b <= 0; dir_b <= 64'hFFFF; h1_b <= 0; h2_b <= 0; rd_b <= 0;
      lat_c <= 0; h1_c <= 0; h2_c <= 0; rd_c <= 0;
    end else begin
      rd_a  <= rdval(rd_en, int'(addr), h2_a, lat_a, dir_a, 1, 1, 32, 0, 0);
      lat_a <= nlat(lat_a, to_lines({32'h0, wdata}, 32, 0, 0), int'(addr), wr_en);
      if (wr_en && addr == 4'd3) dir_a <= to_lines({32'h0, wdata}, 32, 0, 0);
      h2_a <= h1_a; h1_a <= {32'h0, pin_a};

      rd_b  <= rdval(rd_en, int'(addr), h2_b, lat_b, dir_b, 0, 1, 16, 1, 1);
      lat_b <= nlat(lat_b, to_lines({48'h0, wdata[15:0]}, 16, 1, 1), int'(addr), wr_en);
      if (wr_en && addr == 4'd3) dir_b <= to_lines({48'h0, wdata[15:0]}, 16, 1, 1);
      h2_b <= h1_b; h1_b <= {48'h0, pin_b};

      rd_c  <= rdval(rd_en, int'(addr), h2_c, lat_c, 64'h0, 1, 0, 8, 0, 0);
      lat_c <= nlat(lat_c, to_lines({56'h0, wdata[7:0]}, 8, 0, 0), int'(addr), wr_en);
      h2_c <= h1_c; h1_c <= {56'h0, pin_c};
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (run_cmp && !finished) begin
      check("R2 R3 R4 (A out)", {32'h0, out_a}, lat_a);
      check("R5 (A oe)",        {32'h0, oe_a},  dir_a);
      check("R8 (A rd)",        {32'h0, rdata_a}, rd_a);
      check("R6 R7 (B out)",    {48'h0, out_b}, lat_b);
      check("R5 (B oe)",        {48'h0, oe_b},  {48'h0, ~dir_b[15:0]});
      check("R8 (B rd)",        {48'h0, rdata_b}, rd_b);
      check("R2 (C out)",       {56'h0, out_c}, lat_c);
      check("R10 (C oe)",       {56'h0, oe_c},  64'hFF);
      check("R11 (C rd)",       {56'h0, rdata_c}, rd_c);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  logic [31:0] qa;
  logic [15:0] qb;
  logic [7:0]  qc;
  task automatic bus_read(logic [3:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    qa = rdata_a; qb = rdata_b; qc = rdata_c;
  endtask

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 A out", {32'h0, out_a}, 0);
    check("R1 A oe",  {32'h0, oe_a}, 0);
    check("R1 B oe",  {48'h0, oe_b}, 0);
    check("R10 C oe at reset", {56'h0, oe_c}, 64'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmp = 1'b1;
    bus_read(4'd3);
    check("R1 A dir read", {32'h0, qa}, 0);
    check("R1 B dir read", {48'h0, qb}, 64'hFFFF);

    // R2 full load; B sees both reversals
    bus_write(4'd0, 32'h1234_5678);
    check("R2 A out", {32'h0, out_a}, 64'h1234_5678);
    check("R6 R7 B out", {48'h0, out_b}, 64'h6A1E);
    check("R2 C out", {56'h0, out_c}, 64'h78);

    // R3 set
    bus_write(4'd1, 32'h0000_FF00);
    check("R3 A out", {32'h0, out_a}, 64'h1234_FF78);
    // R4 clear
    bus_write(4'd2, 32'h1200_0078);
    check("R4 A out", {32'h0, out_a}, 64'h0034_FF00);
    check("R4 C out", {56'h0, out_c}, 64'h00);

    // R9 set readback
    bus_read(4'd1);
    check("R9 A set read", {32'h0, qa}, 64'h0034_FF00);
    check("R9 B set read", {48'h0, qb}, 0);

    // R5 direction polarity; R10 C ignores it
    bus_write(4'd3, 32'hFFFF_0000);
    check("R5 A oe", {32'h0, oe_a}, 64'hFFFF_0000);
    check("R5 B oe", {48'h0, oe_b}, 64'hFFFF);
    check("R10 C oe", {56'h0, oe_c}, 64'hFF);
    bus_read(4'd3);
    check("R10 C dir read", {56'h0, qc}, 0);

    // R11 unmapped write and reads
    bus_write(4'd7, 32'hFFFF_FFFF);
    check("R11 A out hold", {32'h0, out_a}, 64'h0034_FF00);
    check("R11 A oe hold", {32'h0, oe_a}, 64'hFFFF_0000);
    bus_read(4'd9);
    check("R11 A unmapped read", {32'h0, qa}, 0);
    bus_read(4'd2);
    check("R11 A clear read", {32'h0, qa}, 0);

    // R8 synchronizer latency
    pin_a = 32'hA5A5_0F0F; pin_b = 16'h0001; pin_c = 8'h3C;
    bus_read(4'd0);
    check("R8 A old after 1 edge", {32'h0, qa}, 0);
    bus_read(4'd0);
    check("R8 A old after 2 edges", {32'h0, qa}, 0);
    bus_read(4'd0);
    check("R8 A new after 3 edges", {32'h0, qa}, 64'hA5A5_0F0F);
    check("R6 B line0 read", {48'h0, qb}, 64'h0080);
    check("R8 C read", {56'h0, qc}, 64'h3C);

    // more patterns
    bus_write(4'd0, 32'hFFFF_FFFF);
    bus_write(4'd2, 32'h8000_0001);
    check("R4 A edge bits", {32'h0, out_a}, 64'h7FFF_FFFE);
    bus_write(4'd1, 32'h0000_0000);
    check("R3 A zero mask", {32'h0, out_a}, 64'h7FFF_FFFE);
    bus_write(4'd2, 32'h0000_0000);
    check("R4 A zero mask", {32'h0, out_a}, 64'h7FFF_FFFE);
    bus_write(4'd0, 32'h0000_0001);
    bus_write(4'd1, 32'h0000_0100);
    bus_read(4'd1);
    check("R9 A after set", {32'h0, qa}, 64'h0000_0101);
    pin_b = 16'h8000;
    repeat (3) @(negedge clk);
    bus_read(4'd0);
    check("R6 B line15 read", {48'h0, qb}, 64'h0100);
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule